// File: doc/BRIEF.md
# Hourly Chime Tone Generator

This block sits beside the timekeeping counters of a 24-hour clock and sounds a buzzer in the last seconds of every hour. It reads the current minute and second as four BCD digits. It makes a short low-pitched beep on each even second from 59:50 through 59:58, and then one high-pitched beep when the time reaches 00:00. The counting of time, setting the time and driving a display are handled by other blocks.

The block runs on a fast system clock. It looks at the digits only in the cycle where the one-pulse-per-second strobe is high. At that moment the digits already show the second that is just starting. A beep that belongs to that second then lasts one full second, up to the next strobe. While a beep is active, the buzzer pin carries a square wave. The low beep's period is `LOW_DIV` system clocks. The high beep's period is half of that, which puts it one octave higher. The tone divider restarts at the start of every beep, so all beeps begin with the same phase. Two flags show which tone is sounding.

The block has no data stream, so every pin is a plain level or a strobe with no handshake.

Top module: `hourly_chime`

## Requirements
- R1: A strobe that samples minute tens = 5 and minute units = 9, together with second tens = 5 and second units = 0, 2, 4, 6 or 8, raises `low_active` from the cycle after that strobe until the cycle after the next strobe.
- R2: A strobe that samples all four digits as 0 (time xx:00:00) raises `high_active` for the same one-second window.
- R3: Any other sampled time clears both flags for that second. This includes the odd seconds 51 to 59 of minute 59 and second 50 of any minute other than 59.
- R4: `low_active` and `high_active` are never high in the same cycle.
- R5: Digits that change between strobes have no effect. The flags change only in the cycle after a strobe.
- R6: During a low beep, the buzzer toggles every `LOW_DIV/2` clocks, giving a period of `LOW_DIV` clocks.
- R7: During a high beep, the buzzer toggles every `LOW_DIV/4` clocks, giving a period of `LOW_DIV/2` clocks.
- R8: The buzzer is low in every cycle in which neither flag is high.
- R9: Each beep begins with the buzzer low. Its first rising edge follows the strobe edge by exactly 1 + (half its period) clocks.
- R10: Holding `rst_n` low at a clock edge clears both flags and the buzzer. This is true even when a strobe that decodes a beep second arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sec_tick | input | 1 | One-cycle strobe that marks the start of each second |
| min_tens | input | 4 | BCD tens digit of the minute |
| min_ones | input | 4 | BCD units digit of the minute |
| sec_tens | input | 4 | BCD tens digit of the second |
| sec_ones | input | 4 | BCD units digit of the second |
| buzzer | output | 1 | Square-wave tone output, low when no beep is active |
| low_active | output | 1 | High while a low-pitch beep is sounding |
| high_active | output | 1 | High while the high-pitch beep is sounding |

## Verification
In a single cycle, the strobe edge both loads the new beep flags and restarts the tone divider. The bench checks this by measuring, for every beep second, how many cycles pass from the strobe to the first buzzer rise, and by checking that the buzzer is low in the first cycle of the beep. A reset can also land in the same cycle as a strobe that decodes 59:50. The bench drives both in one cycle and expects both flags and the buzzer to stay low, so reset has to win. In a third case, digits are changed in the middle of a second without a strobe. The flags must not move, and the bench checks this at the pins.

// File: rtl/chime_pkg.sv
package chime_pkg;

  typedef enum logic [1:0] {
    CHIME_NONE = 2'd0,
    CHIME_LOW  = 2'd1,
    CHIME_HIGH = 2'd2
  } chime_e;

  typedef struct packed {
    logic [3:0] mt;
    logic [3:0] mo;
    logic [3:0] st;
    logic [3:0] so;
  } bcd_time_t;

  function automatic logic bcd_is_even(input logic [3:0] d);
    return (d <= 4'd8) && !d[0];
  endfunction

endpackage

// File: rtl/chime_decode.sv
module chime_decode
  import chime_pkg::*;
(
  input  bcd_time_t t,
  output chime_e    kind
);
  logic last_minute;
  logic low_window;
  logic top_of_hour;

  always_comb begin
    last_minute = (t.mt == 4'd5) && (t.mo == 4'd9);
    low_window  = last_minute && (t.st == 4'd5) && bcd_is_even(t.so);
    top_of_hour = (t.mt == 4'd0) && (t.mo == 4'd0) &&
                  (t.st == 4'd0) && (t.so == 4'd0);
    if (low_window)       kind = CHIME_LOW;
    else if (top_of_hour) kind = CHIME_HIGH;
    else                  kind = CHIME_NONE;
  end
endmodule

// File: rtl/chime_seq.sv
module chime_seq
  import chime_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  chime_e kind,
  output logic   low_q,
  output logic   high_q,
  output logic   start_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_q   <= 1'b0;
      high_q  <= 1'b0;
      start_q <= 1'b0;
    end else if (tick) begin
      low_q   <= (kind == CHIME_LOW);
      high_q  <= (kind == CHIME_HIGH);
      start_q <= (kind != CHIME_NONE);
    end else begin
      start_q <= 1'b0;
    end
  end
endmodule

// File: rtl/chime_tone.sv
module chime_tone #(
  parameter int LOW_DIV = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic high_sel,
  input  logic restart,
  output logic tone_q
);
  localparam int LOW_HALF  = LOW_DIV / 2;
  localparam int HIGH_DIV  = LOW_DIV / 2;
  localparam int HIGH_HALF = HIGH_DIV / 2;
  localparam int CW        = (LOW_HALF > 1) ? $clog2(LOW_HALF) : 1;
  localparam logic [CW-1:0] LOW_LAST  = CW'(LOW_HALF - 1);
  localparam logic [CW-1:0] HIGH_LAST = CW'(HIGH_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last = high_sel ? HIGH_LAST : LOW_LAST;

  always_ff @(posedge clk) begin
    if (!rst_n || !active || restart) begin
      cnt_q  <= '0;
      tone_q <= 1'b0;
    end else if (cnt_q == last) begin
      cnt_q  <= '0;
      tone_q <= ~tone_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/hourly_chime.sv
module hourly_chime
  import chime_pkg::*;
#(
  parameter int LOW_DIV = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic [3:0] min_tens,
  input  logic [3:0] min_ones,
  input  logic [3:0] sec_tens,
  input  logic [3:0] sec_ones,
  output logic       buzzer,
  output logic       low_active,
  output logic       high_active
);
  bcd_time_t now;
  chime_e    kind;
  logic      start_q;
  logic      tone_q;

  assign now = '{mt: min_tens, mo: min_ones, st: sec_tens, so: sec_ones};

  chime_decode u_dec (
    .t    (now),
    .kind (kind)
  );

  chime_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (sec_tick),
    .kind    (kind),
    .low_q   (low_active),
    .high_q  (high_active),
    .start_q (start_q)
  );

  chime_tone #(.LOW_DIV(LOW_DIV)) u_tone (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (low_active | high_active),
    .high_sel (high_active),
    .restart  (start_q),
    .tone_q   (tone_q)
  );

  assign buzzer = tone_q & (low_active | high_active);
endmodule

// File: rtl/chime_checks.sv
module chime_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       sec_tick,
  input logic [3:0] min_tens,
  input logic [3:0] min_ones,
  input logic [3:0] sec_tens,
  input logic [3:0] sec_ones,
  input logic       buzzer,
  input logic       low_active,
  input logic       high_active
);
  logic at_low_sec;
  logic at_hour;
  assign at_low_sec = (min_tens == 4'd5) && (min_ones == 4'd9) && (sec_tens == 4'd5) &&
                      (sec_ones <= 4'd8) && !sec_ones[0];
  assign at_hour = (min_tens == 4'd0) && (min_ones == 4'd0) &&
                   (sec_tens == 4'd0) && (sec_ones == 4'd0);

  AST_LOW_ON_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick && at_low_sec |=> low_active && !high_active); // R1
  AST_HIGH_ON_HOUR: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick && at_hour |=> high_active && !low_active); // R2
  AST_SILENT_ELSE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick && !at_low_sec && !at_hour |=> !low_active && !high_active); // R3
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(low_active && high_active)); // R4
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> $stable(low_active) && $stable(high_active)); // R5
  AST_BUZZ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !low_active && !high_active |-> !buzzer); // R8
  AST_BEEP_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(low_active) || $rose(high_active) |-> !buzzer); // R9
  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> !low_active && !high_active && !buzzer); // R10
endmodule

bind hourly_chime chime_checks u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sec_tick    (sec_tick),
  .min_tens    (min_tens),
  .min_ones    (min_ones),
  .sec_tens    (sec_tens),
  .sec_ones    (sec_ones),
  .buzzer      (buzzer),
  .low_active  (low_active),
  .high_active (high_active)
);

// File: tb/tb_hourly_chime.sv
`timescale 1ns/1ps
module tb_hourly_chime;
  localparam int LOW_DIV = 16;
  localparam int GAP     = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 1'b0;
  logic [3:0] min_tens = 4'd5, min_ones = 4'd9, sec_tens = 4'd4, sec_ones = 4'd4;
  logic buzzer, low_active, high_active;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  hourly_chime #(.LOW_DIV(LOW_DIV)) dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .min_tens(min_tens), .min_ones(min_ones), .sec_tens(sec_tens), .sec_ones(sec_ones),
    .buzzer(buzzer), .low_active(low_active), .high_active(high_active)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_second(input int m, input int s);
    bit exp_low, exp_high;
    int half, prev, first_rise, last_edge, bad_int, edges, hi_cnt, both;
    string ftag;
    exp_low  = (m == 59) && (s >= 50) && (s % 2 == 0);
    exp_high = (m == 0) && (s == 0);
    half = exp_high ? LOW_DIV / 4 : LOW_DIV / 2;
    ftag = exp_low ? "R1 low flag" : (exp_high ? "R2 high flag" : "R3 silent flags");
    @(negedge clk);
    min_tens = 4'(m / 10); min_ones = 4'(m % 10);
    sec_tens = 4'(s / 10); sec_ones = 4'(s % 10);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    check(low_active == exp_low && high_active == exp_high, ftag,
          {low_active, high_active}, {exp_low, exp_high});
    prev = buzzer; first_rise = -1; last_edge = -1; bad_int = 0; edges = 0;
    hi_cnt = 0; both = 0;
    if (exp_low || exp_high)
      check(buzzer == 1'b0, "R9 beep starts low", buzzer, 0);
    for (int k = 1; k < GAP; k++) begin
      @(negedge clk);
      if (low_active && high_active) both++;
      if (!low_active && !high_active && buzzer) hi_cnt++;
      if (buzzer != prev) begin
        if (first_rise < 0) first_rise = k;
        else if (k - last_edge != half) bad_int++;
        last_edge = k;
        edges++;
      end
      prev = buzzer;
    end
    check(both == 0, "R4 flags exclusive", both, 0);
    check(low_active == exp_low && high_active == exp_high, "R5 flags held all second",
          {low_active, high_active}, {exp_low, exp_high});
    if (exp_low || exp_high) begin
      check(first_rise == 1 + half, "R9 first rise offset", first_rise, 1 + half);
      check(bad_int == 0 && edges > 2, exp_low ? "R6 low period" : "R7 high period",
            bad_int, 0);
    end else begin
      check(hi_cnt == 0 && edges == 0, "R8 buzzer quiet", hi_cnt + edges, 0);
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!low_active && !high_active && !buzzer, "R10 reset state",
          {low_active, high_active, buzzer}, 0);
    rst_n = 1'b1;
    for (int s = 45; s < 60; s++) run_second(59, s);
    for (int s = 0; s < 6; s++) run_second(0, s);
    for (int s = 0; s < 60; s++) run_second(58, s);
    for (int s = 0; s < 60; s++) run_second(59, s);
    for (int s = 0; s < 60; s++) run_second(0, s);
    for (int s = 48; s < 60; s++) run_second(49, s);
    for (int s = 48; s < 53; s++) run_second(9, s);
    run_second(59, 51);
    @(negedge clk);
    sec_tens = 4'd5; sec_ones = 4'd2;
    repeat (20) @(negedge clk);
    check(!low_active && !high_active, "R5 digits ignored without strobe",
          {low_active, high_active}, 0);
    @(negedge clk);
    min_tens = 4'd5; min_ones = 4'd9; sec_tens = 4'd5; sec_ones = 4'd0;
    sec_tick = 1'b1; rst_n = 1'b0;
    @(negedge clk);
    sec_tick = 1'b0;
    check(!low_active && !high_active && !buzzer, "R10 reset beats strobe",
          {low_active, high_active, buzzer}, 0);
    repeat (10) @(negedge clk);
    check(!low_active && !high_active && !buzzer, "R10 stays cleared",
          {low_active, high_active, buzzer}, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule